// File: doc/BRIEF.md
# Trace Event Input Selector

This block sits inside an instruction-trace unit. It turns a wide pool of activity signals into at most four trace events per cycle. The pool has two parts: a small external input bus, and a wider performance-monitor event bus. The monitor bus only contributes when its global export enable is high. Four input selector fields each pick one pool signal. All four fields use a single number space: the external bits come first, and the monitor bits follow at a fixed offset.

Each picked signal passes through a two-stage synchronizer. A rising edge at the synchronizer output becomes a one-cycle pulse. Resource selectors then forward these pulses. Each of the four trace events follows one resource selector, chosen through its own map field.

The block emits three outputs:
- a per-event pulse vector for decrement counters and timestamp requests, which ignores the packet enables;
- a masked event bit vector for the event trace packet;
- a packet-valid strobe.

Packet formatting and serialization are outside this block.

Top module: `trc_evt_sel`

## Requirements
- R1: Input selector n sits in `cfg_insel_i[n*8 +: 8]`. A value v from 0 to 3 picks `ext_i[v]`.
- R2: A selector value v from 4 to 35 picks `mon_i[v-4]`. For example, 12 picks monitor bit 8 and 29 picks monitor bit 25.
- R3: While `mon_en_i` is low, every monitor bit reads as zero. Raising `mon_en_i` while a selected monitor bit is high counts as a rising edge.
- R4: A selector value of 36 or more reads as constant zero and never produces a pulse.
- R5: Resource selector r uses two fields: group `cfg_rs_grp_i[r*4 +: 4]` and select `cfg_rs_sel_i[r*4 +: 4]`. With group 0 and select n below 4, it follows the pulse of input selector n. Any other group, or a select value of 4 or more, gives zero.
- R6: Trace event e follows the resource selector whose index is in `cfg_evmap_i[e*3 +: 3]`. Several events may follow the same resource selector.
- R7: A low-to-high change on a selected input, applied before clock edge k, produces exactly one cycle of pulse on the mapped outputs, visible after edge k+2. A steady high level or a falling edge produces nothing.
- R8: `evt_bits_o[e]` equals the event pulse ANDed with `cfg_evt_en_i[e]`. Bits of disabled events are zero.
- R9: `evt_pulse_o[e]` pulses for every event occurrence, whatever the state of `cfg_evt_en_i`.
- R10: `pkt_valid_o` is high exactly in the cycles where `evt_bits_o` is non-zero.
- R11: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| ext_i | input | 4 | External input bus |
| mon_i | input | 32 | Performance-monitor event bus |
| mon_en_i | input | 1 | Global export enable for the monitor bus |
| cfg_insel_i | input | 32 | Four 8-bit input selector fields |
| cfg_rs_grp_i | input | 32 | Eight 4-bit resource selector group fields |
| cfg_rs_sel_i | input | 32 | Eight 4-bit resource selector select fields |
| cfg_evmap_i | input | 12 | Four 3-bit event-to-resource map fields |
| cfg_evt_en_i | input | 4 | Packet enable for each event |
| evt_bits_o | output | 4 | Masked event bits for the packet |
| pkt_valid_o | output | 1 | High when any packet event bit is set |
| evt_pulse_o | output | 4 | Unmasked event pulses for counters and timestamps |

## Verification
Three registers lie between a selected input and the outputs: two synchronizer stages and the output register. The edge detector uses a third flop alongside them. A rise driven just after the edge counted as cycle c is therefore visible after edge c+3, and it lasts one cycle. For each stimulus, the driver records the expected result under cycle c+3. The monitor samples at every falling clock edge. When the recorded cycle number comes up, it compares against that entry. In every other cycle it requires all outputs to be zero, which catches late, early, doubled and spurious pulses. Configuration is changed only while all pool inputs are low, so a change of selection cannot create an edge that was not planned.

// File: rtl/trc_evt_pkg.sv
package trc_evt_pkg;

    // Architectural counts: four input selectors feed four trace events.
    localparam int NUM_SEL = 4;
    localparam int NUM_EVT = 4;

    // Synchronizer chain plus the history flop used for edge detection.
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    // Registered outputs of the block.
    typedef struct packed {
        logic [NUM_EVT-1:0] pulse;
        logic [NUM_EVT-1:0] bits;
        logic               valid;
    } out_t;

endpackage

// File: rtl/trc_evt_insel.sv
module trc_evt_insel
    import trc_evt_pkg::*;
#(
    parameter int EXT_W = 4,
    parameter int MON_W = 32,
    parameter int SEL_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [EXT_W-1:0] ext_i,
    input  logic [MON_W-1:0] mon_i,
    input  logic             mon_en_i,
    output logic             pulse_o
);

    logic  raw;
    sync_t sync_d, sync_q;

    // Single number space: external bits first, monitor bits at offset EXT_W.
    // Values past the end of the pool leave raw at zero.
    always_comb begin
        raw = 1'b0;
        for (int i = 0; i < EXT_W; i++) begin
            if (sel_i == SEL_W'(i)) raw = ext_i[i];
        end
        for (int j = 0; j < MON_W; j++) begin
            if (sel_i == SEL_W'(j + EXT_W)) raw = mon_i[j] & mon_en_i;
        end
    end

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = raw;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign pulse_o = sync_q.s2 & ~sync_q.s3;

    // R7
    no_double_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);

    // R3
    mon_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mon_en_i && (sel_i >= SEL_W'(EXT_W))) |=> !sync_q.s1);

endmodule

// File: rtl/trc_evt_route.sv
module trc_evt_route
    import trc_evt_pkg::*;
#(
    parameter int NUM_RES = 8,
    parameter int GRP_W   = 4,
    parameter int RSEL_W  = 4,
    parameter int MAP_W   = 3
) (
    input  logic [NUM_SEL-1:0]        pulse_i,
    input  logic [NUM_RES*GRP_W-1:0]  rs_grp_i,
    input  logic [NUM_RES*RSEL_W-1:0] rs_sel_i,
    input  logic [NUM_EVT*MAP_W-1:0]  evmap_i,
    output logic [NUM_EVT-1:0]        evt_o
);

    logic [NUM_RES-1:0] rs_hit;

    // Resource selectors: only group 0 forwards an input selector pulse.
    for (genvar r = 0; r < NUM_RES; r++) begin : g_rs
        logic [GRP_W-1:0]  grp;
        logic [RSEL_W-1:0] idx;
        logic              hit;
        assign grp = rs_grp_i[r*GRP_W +: GRP_W];
        assign idx = rs_sel_i[r*RSEL_W +: RSEL_W];
        always_comb begin
            hit = 1'b0;
            for (int n = 0; n < NUM_SEL; n++) begin
                if (grp == '0 && idx == RSEL_W'(n)) hit = pulse_i[n];
            end
        end
        assign rs_hit[r] = hit;
    end

    // Event map: each event follows one resource selector.
    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        logic [MAP_W-1:0] map;
        logic             fire;
        assign map = evmap_i[e*MAP_W +: MAP_W];
        always_comb begin
            fire = 1'b0;
            for (int r = 0; r < NUM_RES; r++) begin
                if (map == MAP_W'(r)) fire = rs_hit[r];
            end
        end
        assign evt_o[e] = fire;
    end

endmodule

// File: rtl/trc_evt_sel.sv
module trc_evt_sel
    import trc_evt_pkg::*;
#(
    parameter int EXT_W   = 4,
    parameter int MON_W   = 32,
    parameter int SEL_W   = 8,
    parameter int NUM_RES = 8,
    parameter int GRP_W   = 4,
    parameter int RSEL_W  = 4,
    parameter int MAP_W   = $clog2(NUM_RES)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [EXT_W-1:0]          ext_i,
    input  logic [MON_W-1:0]          mon_i,
    input  logic                      mon_en_i,
    input  logic [NUM_SEL*SEL_W-1:0]  cfg_insel_i,
    input  logic [NUM_RES*GRP_W-1:0]  cfg_rs_grp_i,
    input  logic [NUM_RES*RSEL_W-1:0] cfg_rs_sel_i,
    input  logic [NUM_EVT*MAP_W-1:0]  cfg_evmap_i,
    input  logic [NUM_EVT-1:0]        cfg_evt_en_i,
    output logic [NUM_EVT-1:0]        evt_bits_o,
    output logic                      pkt_valid_o,
    output logic [NUM_EVT-1:0]        evt_pulse_o
);

    logic [NUM_SEL-1:0] sel_pulse;
    logic [NUM_EVT-1:0] evt_raw;
    out_t               out_d, out_q;

    for (genvar n = 0; n < NUM_SEL; n++) begin : g_in
        trc_evt_insel #(
            .EXT_W (EXT_W),
            .MON_W (MON_W),
            .SEL_W (SEL_W)
        ) u_insel (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .sel_i    (cfg_insel_i[n*SEL_W +: SEL_W]),
            .ext_i    (ext_i),
            .mon_i    (mon_i),
            .mon_en_i (mon_en_i),
            .pulse_o  (sel_pulse[n])
        );
    end

    trc_evt_route #(
        .NUM_RES (NUM_RES),
        .GRP_W   (GRP_W),
        .RSEL_W  (RSEL_W),
        .MAP_W   (MAP_W)
    ) u_route (
        .pulse_i  (sel_pulse),
        .rs_grp_i (cfg_rs_grp_i),
        .rs_sel_i (cfg_rs_sel_i),
        .evmap_i  (cfg_evmap_i),
        .evt_o    (evt_raw)
    );

    always_comb begin
        out_d       = out_q;
        out_d.pulse = evt_raw;
        out_d.bits  = evt_raw & cfg_evt_en_i;
        out_d.valid = |(evt_raw & cfg_evt_en_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign evt_bits_o  = out_q.bits;
    assign pkt_valid_o = out_q.valid;
    assign evt_pulse_o = out_q.pulse;

    // R8
    masked_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_bits_o & ~$past(cfg_evt_en_i)) == '0);

    // R10
    valid_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_valid_o == (evt_bits_o != '0));

    // R9
    bits_in_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_bits_o & ~evt_pulse_o) == '0);

endmodule

// File: tb/sim_trc_evt_sel.sv
module sim_trc_evt_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ext = '0;
    logic [31:0] mon = '0;
    logic        mon_en = 1'b1;
    logic [31:0] insel;
    logic [31:0] rs_grp;
    logic [31:0] rs_sel;
    logic [11:0] evmap;
    logic [3:0]  en;
    logic [3:0]  bits;
    logic        valid;
    logic [3:0]  pulse;

    always #4 clk = ~clk;

    trc_evt_sel u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .ext_i        (ext),
        .mon_i        (mon),
        .mon_en_i     (mon_en),
        .cfg_insel_i  (insel),
        .cfg_rs_grp_i (rs_grp),
        .cfg_rs_sel_i (rs_sel),
        .cfg_evmap_i  (evmap),
        .cfg_evt_en_i (en),
        .evt_bits_o   (bits),
        .pkt_valid_o  (valid),
        .evt_pulse_o  (pulse)
    );

    typedef struct {
        int         cyc;
        logic [3:0] pulse;
        logic [3:0] bits;
        logic       valid;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   run = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input logic [3:0] ep, input logic [3:0] eb, input string tag);
        exp_t e;
        e.cyc   = cyc + 3;
        e.pulse = ep;
        e.bits  = eb;
        e.valid = |eb;
        e.tag   = tag;
        sbq.push_back(e);
    endtask

    // Raise one pool input, record the expected result, then drop it again.
    task automatic fire(input bit is_mon, input int b, input logic [3:0] ep,
                        input logic [3:0] eb, input string tag);
        @(negedge clk);
        if (is_mon) mon[b] = 1'b1; else ext[b] = 1'b1;
        if (ep != '0) push(ep, eb, tag);
        repeat (5) @(negedge clk);
        if (is_mon) mon[b] = 1'b0; else ext[b] = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Monitor: compare against a due entry, otherwise demand silence.
    initial begin
        forever begin
            @(negedge clk);
            if (run) begin
                exp_t e;
                if (sbq.size() > 0 && sbq[0].cyc == cyc) begin
                    e = sbq.pop_front();
                end else begin
                    e.cyc = cyc; e.pulse = '0; e.bits = '0; e.valid = 1'b0;
                    e.tag = "R7 idle";
                end
                total++;
                if (pulse !== e.pulse || bits !== e.bits || valid !== e.valid) begin
                    bad++;
                    $display("FAIL %s cyc=%0d actual pulse=%b bits=%b valid=%b expected pulse=%b bits=%b valid=%b",
                             e.tag, cyc, pulse, bits, valid, e.pulse, e.bits, e.valid);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        insel  = {8'd2, 8'd29, 8'd12, 8'd0};
        rs_grp = 32'h0001_0000;
        rs_sel = 32'h0150_3210;
        evmap  = {3'd3, 3'd2, 3'd1, 3'd0};
        en     = 4'b1111;

        // R11: outputs zero under reset, even with inputs active
        repeat (3) @(negedge clk);
        ext = 4'b1111;
        repeat (2) @(negedge clk);
        total++;
        if (bits !== 4'b0 || valid !== 1'b0 || pulse !== 4'b0) begin
            bad++;
            $display("FAIL R11 actual bits=%b valid=%b pulse=%b expected all zero", bits, valid, pulse);
        end
        ext = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        run = 1'b1;

        // R1: external bits through selectors 0 and 3; unselected bit is silent
        fire(0, 0, 4'b0001, 4'b0001, "R1 ext0");
        fire(0, 1, 4'b0000, 4'b0000, "R1 ext1 unselected");
        fire(0, 2, 4'b1000, 4'b1000, "R1 ext2");

        // R2: offset into the monitor bus
        fire(1, 8,  4'b0010, 4'b0010, "R2 mon8 via 12");
        fire(1, 25, 4'b0100, 4'b0100, "R2 mon25 via 29");
        fire(1, 12, 4'b0000, 4'b0000, "R2 mon12 unselected");

        // R8 / R9 / R10: packet enables mask bits only
        @(negedge clk); en = 4'b0101;
        fire(1, 8, 4'b0010, 4'b0000, "R9 pulse without packet bit");
        fire(0, 0, 4'b0001, 4'b0001, "R8 enabled bit");
        @(negedge clk); en = 4'b1111;

        // R3: export enable gates the monitor bus
        @(negedge clk); mon_en = 1'b0;
        fire(1, 8, 4'b0000, 4'b0000, "R3 gated");
        @(negedge clk); mon[8] = 1'b1;
        repeat (5) @(negedge clk);
        mon_en = 1'b1;
        push(4'b0010, 4'b0010, "R3 enable rise");
        repeat (6) @(negedge clk);
        mon[8] = 1'b0;
        repeat (5) @(negedge clk);

        // R4: selector past the pool end reads zero
        insel[7:0] = 8'd40;
        @(negedge clk); mon = '1;
        push(4'b0110, 4'b0110, "R4 out-of-range silent");
        repeat (5) @(negedge clk);
        mon = '0;
        repeat (5) @(negedge clk);
        insel[7:0] = 8'd35;
        fire(1, 31, 4'b0001, 4'b0001, "R2 last monitor bit via 35");
        insel[7:0] = 8'd0;
        repeat (2) @(negedge clk);

        // R5 / R6: resource selector group/select and event map
        evmap[2:0] = 3'd4;
        fire(0, 0, 4'b0000, 4'b0000, "R5 nonzero group");
        evmap[2:0] = 3'd5;
        fire(0, 0, 4'b0000, 4'b0000, "R5 select out of range");
        evmap[2:0] = 3'd7;
        fire(0, 0, 4'b0001, 4'b0001, "R6 map to rs7");
        evmap[8:6] = 3'd6;
        fire(1, 8, 4'b0110, 4'b0110, "R6 shared source");
        evmap = {3'd3, 3'd2, 3'd1, 3'd0};

        // R7: two selectors rising together, pulses only once
        @(negedge clk); ext[0] = 1'b1; ext[2] = 1'b1;
        push(4'b1001, 4'b1001, "R7 simultaneous");
        repeat (8) @(negedge clk);
        ext = '0;
        repeat (6) @(negedge clk);

        total++;
        if (sbq.size() != 0) begin
            bad++;
            $display("FAIL R7 leftover actual=%0d expected=0", sbq.size());
        end
        summary();
        $finish;
    end

endmodule